// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Unit

This block holds two 16-bit timer/counters of the kind found beside a small 8-bit processor core. Each channel has a low and a high count byte, a 4-bit field in a shared mode byte, and a run bit and an overflow flag in a shared control byte. A channel advances on one of two events. The first is an internal tick that fires once every twelve clocks. The second is a falling edge on its external count pin, sampled on that tick. A channel can also be gated by an external gate pin. Four count organisations are available: a 13-bit counter with a 5-bit low prescaler, a full 16-bit counter, an 8-bit counter with auto-reload from the high byte, and a split mode in which timer 0 becomes two independent 8-bit counters.

Software writes and reads all registers through a simple byte port: one write strobe with address and data, and a combinational read address. The overflow flags are driven out directly so that an interrupt controller can watch them. That controller clears a flag through a per-channel acknowledge input.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, every register reads 00h, both overflow outputs are 0, and the count-pin samplers hold 0.
- R2: The register addresses are: 0 = mode byte, 1 = control byte, 2 = timer 0 low, 3 = timer 0 high, 4 = timer 1 low, 5 = timer 1 high. Addresses 6 and 7 read 00h, and writes to them have no effect. The mode byte holds gate, C/T, M1 and M0 for timer 1 in bits 7..4 and for timer 0 in bits 3..0. The control byte holds run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3; bits 7..4 read 0.
- R3: A channel advances only on a cycle where its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R4: An internal tick fires once every 12 clocks. With C/T = 0 the channel counts ticks. With C/T = 1 it counts falling edges of its count pin: the pin is sampled on each tick, and a count is taken on a tick where the previous sample was 1 and the current level is 0.
- R5: Mode 0 (M1 M0 = 00) counts a 13-bit value made of the high byte above the low 5 bits of the low byte. Bits 7..5 of the low byte are not changed by counting. Wrapping from 1FFFh to 0 sets the channel flag.
- R6: Mode 1 (01) counts the high:low pair as one 16-bit value. Wrapping from FFFFh to 0 sets the flag.
- R7: Mode 2 (10) counts the low byte only. When it overflows from FFh, it is loaded from the high byte and the flag is set; the high byte is unchanged.
- R8: With timer 1 in mode 3 (11), timer 1 holds both of its count bytes.
- R9: With timer 0 in mode 3, timer 0 low counts as an 8-bit counter under timer 0's run, gate, C/T and flag0. Timer 0 high counts ticks only while run1 is 1, ignores all gating, and sets flag1 when it wraps. While timer 0 is in mode 3, timer 1 ignores run1, still obeys its own gate, and never sets flag1.
- R10: A flag is set by its channel's wrap and cleared by its acknowledge input or by a control-byte write of 0 to it. On the same cycle, a hardware set wins over the acknowledge input, and the acknowledge input wins over the write.
- R11: A software write to a count byte on the same cycle as an increment stores the written value in that byte. The other byte still takes its increment or carry.
- R12: Setting or clearing a run bit does not change the count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| cnt_pin_i | input | 2 | External count pins, bit i for timer i |
| gate_pin_i | input | 2 | External gate pins, bit i for timer i |
| ack_i | input | 2 | Flag clear from the interrupt controller |
| ovf_o | output | 2 | Overflow flags |

## Verification
The hardest state to reach from the ports is the split mode. In that mode timer 0 high borrows run1 and flag1, while timer 1 keeps counting with neither. Only a sequence of mode, preset and control writes exposes a wrong owner of flag1 or of the run bit. The stimulus presets the counts just below their wrap points and then switches run1 on and off. It shows that timer 0 high sets flag1 while a wrapping timer 1 does not. The edge-counting cases use pin levels held longer than the tick period. This makes the expected count independent of the tick phase. A behavioural model also tracks the phase exactly and compares every register on every clock.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;
  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } mode_e;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_CTL  = 1;
  localparam int ADDR_CNT0 = 2;  // lo0, hi0, lo1, hi1 follow
endpackage

// File: rtl/dtu_tick_gen.sv
`timescale 1ns/1ps
module dtu_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dtu_fall_detect.sv
`timescale 1ns/1ps
module dtu_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else if (tick_i) prev_q <= pin_i;
  end

  assign fall_o = tick_i & prev_q & ~pin_i;
endmodule

// File: rtl/dtu_count_core.sv
`timescale 1ns/1ps
module dtu_count_core
  import dtu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          step_i,
  input  logic          step_hi_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          wrap_o,
  output logic          hi_wrap_o
);
  localparam int SW = DW + PRE_W;
  localparam int FW = 2 * DW;

  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [SW-1:0] sum13;
  logic [FW-1:0] sum16;

  assign sum13 = {hi_q, lo_q[PRE_W-1:0]} + SW'(1);
  assign sum16 = {hi_q, lo_q} + FW'(1);

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    wrap_o    = 1'b0;
    hi_wrap_o = 1'b0;
    case (mode_i)
      MODE_13B: if (step_i) begin
        hi_n             = sum13[SW-1:PRE_W];
        lo_n[PRE_W-1:0]  = sum13[PRE_W-1:0];
        wrap_o           = &{hi_q, lo_q[PRE_W-1:0]};
      end
      MODE_16B: if (step_i) begin
        {hi_n, lo_n} = sum16;
        wrap_o       = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (step_i) begin
        if (&lo_q) begin
          lo_n   = hi_q;
          wrap_o = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      default: begin
        if (step_i) begin
          lo_n   = lo_q + 1'b1;
          wrap_o = &lo_q;
        end
        if (step_hi_i) begin
          hi_n      = hi_q + 1'b1;
          hi_wrap_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/dual_timer_unit.sv
`timescale 1ns/1ps
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter int PRE_W    = 5,
  parameter int TICK_DIV = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [1:0]    cnt_pin_i,
  input  logic [1:0]    gate_pin_i,
  input  logic [1:0]    ack_i,
  output logic [1:0]    ovf_o
);
  localparam int NCH = 2;
  localparam int FLD = 4;

  logic [DW-1:0]          mode_q;
  logic [NCH-1:0]         run_q, flag_q, flag_n;
  logic                   tick_w, split_w, ctl_wr_w;
  logic [NCH-1:0]         fall_w, evt_w, gate_ok_w, run_eff_w;
  logic [NCH-1:0]         step_w, step_hi_w, wrap_w, hi_wrap_w, set_w;
  logic [NCH-1:0]         wr_lo_w, wr_hi_w;
  logic [NCH-1:0][1:0]    md_w;
  logic [NCH-1:0][DW-1:0] lo_w, hi_w;

  dtu_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  assign split_w  = (mode_e'(md_w[0]) == MODE_SPLIT);
  assign ctl_wr_w = wr_en_i && (wr_addr_i == AW'(ADDR_CTL));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [FLD-1:0] fld;
    assign fld          = mode_q[FLD*i +: FLD];
    assign md_w[i]      = fld[1:0];
    assign gate_ok_w[i] = ~fld[3] | gate_pin_i[i];
    assign evt_w[i]     = fld[2] ? fall_w[i] : tick_w;
    assign wr_lo_w[i]   = wr_en_i && (wr_addr_i == AW'(ADDR_CNT0 + 2*i));
    assign wr_hi_w[i]   = wr_en_i && (wr_addr_i == AW'(ADDR_CNT0 + 2*i + 1));

    dtu_fall_detect u_fall (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_w),
      .pin_i (cnt_pin_i[i]),
      .fall_o(fall_w[i])
    );

    dtu_count_core #(.DW(DW), .PRE_W(PRE_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_e'(md_w[i])),
      .step_i   (step_w[i]),
      .step_hi_i(step_hi_w[i]),
      .wr_lo_i  (wr_lo_w[i]),
      .wr_hi_i  (wr_hi_w[i]),
      .wr_data_i(wr_data_i),
      .lo_o     (lo_w[i]),
      .hi_o     (hi_w[i]),
      .wrap_o   (wrap_w[i]),
      .hi_wrap_o(hi_wrap_w[i])
    );
  end

  // timer 1 loses its run bit to timer 0 high while timer 0 is split
  assign run_eff_w[0] = run_q[0];
  assign run_eff_w[1] = split_w | run_q[1];

  always_comb begin
    step_w[0]    = run_eff_w[0] & gate_ok_w[0] & evt_w[0];
    step_w[1]    = (mode_e'(md_w[1]) != MODE_SPLIT) & run_eff_w[1] & gate_ok_w[1] & evt_w[1];
    step_hi_w[0] = split_w & run_q[1] & tick_w;
    step_hi_w[1] = 1'b0;
    set_w[0]     = wrap_w[0];
    set_w[1]     = split_w ? hi_wrap_w[0] : (wrap_w[1] | hi_wrap_w[1]);
  end

  always_comb begin
    flag_n = ctl_wr_w ? wr_data_i[3:2] : flag_q;
    flag_n = (flag_n & ~ack_i) | set_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_n;
      if (ctl_wr_w) run_q <= wr_data_i[1:0];
      if (wr_en_i && wr_addr_i == AW'(ADDR_MODE)) mode_q <= wr_data_i;
    end
  end

  always_comb begin
    case (rd_addr_i)
      AW'(ADDR_MODE):     rd_data_o = mode_q;
      AW'(ADDR_CTL):      rd_data_o = {{(DW-4){1'b0}}, flag_q, run_q};
      AW'(ADDR_CNT0):     rd_data_o = lo_w[0];
      AW'(ADDR_CNT0 + 1): rd_data_o = hi_w[0];
      AW'(ADDR_CNT0 + 2): rd_data_o = lo_w[1];
      AW'(ADDR_CNT0 + 3): rd_data_o = hi_w[1];
      default:            rd_data_o = '0;
    endcase
  end

  assign ovf_o = flag_q;
endmodule

// File: rtl/dual_timer_unit_chk.sv
`timescale 1ns/1ps
module dual_timer_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [AW-1:0]       wr_addr_i,
  input logic [1:0]          ack_i,
  input logic [1:0]          ovf_o,
  input logic [DW-1:0]       mode_q,
  input logic [1:0]          run_q,
  input logic [1:0]          step_w,
  input logic [1:0]          wrap_w,
  input logic [1:0][DW-1:0]  lo_w,
  input logic [1:0][DW-1:0]  hi_w
);
  logic wr_t0, wr_t1;
  assign wr_t0 = wr_en_i && (wr_addr_i == AW'(2) || wr_addr_i == AW'(3));
  assign wr_t1 = wr_en_i && (wr_addr_i == AW'(4) || wr_addr_i == AW'(5));

  // R12
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !(wr_en_i && wr_addr_i == AW'(2))) |=> $stable(lo_w[0]));

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1:0] == 2'd2 && step_w[0] && lo_w[0] == '1 && !wr_t0)
      |=> (lo_w[0] == $past(hi_w[0]) && ovf_o[0]));

  // R8
  t1_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[5:4] == 2'd3 && !wr_t1) |=> ($stable(lo_w[1]) && $stable(hi_w[1])));

  // R10
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !wrap_w[0]) |=> !ovf_o[0]);

  // R6
  wrap16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1:0] == 2'd1 && step_w[0] && {hi_w[0], lo_w[0]} == '1) |=> ovf_o[0]);
endmodule

bind dual_timer_unit dual_timer_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .ack_i    (ack_i),
  .ovf_o    (ovf_o),
  .mode_q   (mode_q),
  .run_q    (run_q),
  .step_w   (step_w),
  .wrap_w   (wrap_w),
  .lo_w     (lo_w),
  .hi_w     (hi_w)
);

// File: tb/dual_timer_unit_test.sv
`timescale 1ns/1ps
module dual_timer_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ack = '0;
  logic [1:0] ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_timer_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin), .ack_i(ack), .ovf_o(ovf)
  );

  // behavioural reference model
  int m_div, m_mode;
  int m_run[2], m_flag[2], m_lo[2], m_hi[2], m_prev[2];

  always @(posedge clk or negedge rst_n) begin : mdl
    int tk, split, gohi, hw, v;
    int fl[2], md[2], ct[2], gt[2], go[2], wrap[2], nlo[2], nhi[2], runeff[2];
    int fbase[2];
    if (!rst_n) begin
      m_div = 0; m_mode = 0;
      for (int i = 0; i < 2; i++) begin
        m_run[i] = 0; m_flag[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_prev[i] = 0;
      end
    end else begin
      tk = (m_div == 11);
      m_div = tk ? 0 : m_div + 1;
      for (int i = 0; i < 2; i++) begin
        fl[i] = tk && m_prev[i] == 1 && cnt_pin[i] == 1'b0;
        if (tk) m_prev[i] = cnt_pin[i];
        md[i] = (m_mode >> (4*i)) & 3;
        ct[i] = (m_mode >> (4*i + 2)) & 1;
        gt[i] = (m_mode >> (4*i + 3)) & 1;
      end
      split = (md[0] == 3);
      runeff[0] = m_run[0];
      runeff[1] = split ? 1 : m_run[1];
      for (int i = 0; i < 2; i++) begin
        go[i] = runeff[i] && (gt[i] == 0 || gate_pin[i]) && (ct[i] ? fl[i] : tk);
        if (i == 1 && md[1] == 3) go[i] = 0;
        wrap[i] = 0; nlo[i] = m_lo[i]; nhi[i] = m_hi[i];
        if (go[i]) begin
          case (md[i])
            0: begin
              v = m_hi[i] * 32 + (m_lo[i] % 32) + 1;
              wrap[i] = (v == 8192); v = v % 8192;
              nhi[i] = v / 32; nlo[i] = (m_lo[i] & 224) | (v % 32);
            end
            1: begin
              v = m_hi[i] * 256 + m_lo[i] + 1;
              wrap[i] = (v == 65536); v = v % 65536;
              nhi[i] = v / 256; nlo[i] = v % 256;
            end
            2: begin
              if (m_lo[i] == 255) begin nlo[i] = m_hi[i]; wrap[i] = 1; end
              else nlo[i] = m_lo[i] + 1;
            end
            default: begin
              wrap[i] = (m_lo[i] == 255); nlo[i] = (m_lo[i] + 1) % 256;
            end
          endcase
        end
      end
      gohi = split && m_run[1] && tk;
      hw = 0;
      if (gohi) begin hw = (m_hi[0] == 255); nhi[0] = (m_hi[0] + 1) % 256; end
      if (wr_en) begin
        if (wr_addr == 2) nlo[0] = wr_data;
        if (wr_addr == 3) nhi[0] = wr_data;
        if (wr_addr == 4) nlo[1] = wr_data;
        if (wr_addr == 5) nhi[1] = wr_data;
      end
      for (int i = 0; i < 2; i++) begin
        fbase[i] = (wr_en && wr_addr == 1) ? wr_data[2+i] : m_flag[i];
        if (ack[i]) fbase[i] = 0;
      end
      if (wrap[0]) fbase[0] = 1;
      if (split ? hw : wrap[1]) fbase[1] = 1;
      for (int i = 0; i < 2; i++) begin
        m_flag[i] = fbase[i]; m_lo[i] = nlo[i]; m_hi[i] = nhi[i];
      end
      if (wr_en && wr_addr == 1) begin m_run[0] = wr_data[0]; m_run[1] = wr_data[1]; end
      if (wr_en && wr_addr == 0) m_mode = wr_data;
    end
  end

  function automatic int mread(int a);
    case (a)
      0: return m_mode;
      1: return m_flag[1]*8 + m_flag[0]*4 + m_run[1]*2 + m_run[0];
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic rd(int a, int exp, string tag);
    rd_addr = 3'(a);
    #0.1;
    chk(rd_data, exp, tag, $sformatf("addr %0d", a));
  endtask

  // advance one clock and compare every register and flag with the model
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd(a, mread(a), "R2");
    chk(ovf, m_flag[1]*2 + m_flag[0], "R10", "ovf");
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse(int ch);
    cnt_pin[ch] = 1'b1;
    repeat (15) cyc();
    cnt_pin[ch] = 1'b0;
    repeat (15) cyc();
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a, 0, "R1");
    chk(ovf, 0, "R1", "ovf after reset");

    // R2 readback and unused addresses
    wr(2, 8'h12); rd(2, 8'h12, "R2");
    wr(6, 8'h5a); rd(6, 0, "R2");
    wr(7, 8'hff); rd(7, 0, "R2");
    rd(0, 0, "R2");

    // R6 / R4 edge counting in 16-bit mode
    wr(0, 8'h05); wr(2, 8'hfe); wr(3, 8'hff); wr(1, 8'h01);
    pulse(0); pulse(0);
    rd(2, 8'h00, "R6"); rd(3, 8'h00, "R6");
    chk(ovf[0], 1, "R6", "flag0 after 16-bit wrap");
    rd(1, 8'h05, "R2");

    // R10 acknowledge clears
    ack = 2'b01; cyc(); ack = 2'b00;
    chk(ovf[0], 0, "R10", "flag0 after ack");

    // R3 gating
    wr(0, 8'h0d); gate_pin[0] = 1'b0;
    pulse(0); pulse(0);
    rd(2, 8'h00, "R3");
    gate_pin[0] = 1'b1;
    pulse(0);
    rd(2, 8'h01, "R3");

    // R5 13-bit mode
    wr(0, 8'h04); wr(2, 8'hfe); wr(3, 8'hff);
    pulse(0);
    rd(2, 8'hff, "R5");
    pulse(0);
    rd(2, 8'he0, "R5"); rd(3, 8'h00, "R5");
    chk(ovf[0], 1, "R5", "flag0 after 13-bit wrap");

    // R10 software clear, R7 reload
    wr(1, 8'h01);
    chk(ovf[0], 0, "R10", "flag0 after control write");
    wr(0, 8'h06); wr(3, 8'h80); wr(2, 8'hff);
    pulse(0);
    rd(2, 8'h80, "R7"); rd(3, 8'h80, "R7");
    chk(ovf[0], 1, "R7", "flag0 after reload");

    // R12 run toggle keeps counts
    wr(1, 8'h00); wr(1, 8'h01);
    rd(2, 8'h80, "R12"); rd(3, 8'h80, "R12");
    rd(1, 8'h01, "R12");

    // R4 internal tick: 120 clocks give 10 counts
    wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'h00); wr(3, 8'h00);
    wr(1, 8'h01);
    idle(120);
    rd(2, 8'h0a, "R4"); rd(3, 8'h00, "R4");

    // R8 timer 1 frozen in mode 3
    wr(0, 8'h71); wr(4, 8'h10); wr(1, 8'h03);
    pulse(1); pulse(1);
    rd(4, 8'h10, "R8"); rd(5, 8'h00, "R8");

    // R9 split mode
    wr(1, 8'h00); wr(0, 8'h17);
    wr(2, 8'hff); wr(3, 8'hfe); wr(4, 8'h00); wr(5, 8'h00);
    wr(1, 8'h01);
    pulse(0);
    rd(2, 8'h00, "R9"); rd(3, 8'hfe, "R9");
    chk(ovf, 2'b01, "R9", "flags after split low wrap");
    ack = 2'b11; cyc(); ack = 2'b00;
    wr(1, 8'h02);
    idle(24);
    rd(3, 8'h00, "R9");
    chk(ovf, 2'b10, "R9", "flag1 from split high");
    wr(1, 8'h00);
    wr(4, 8'hff); wr(5, 8'hff);
    idle(36);
    chk(ovf[1], 0, "R9", "timer1 wrap must not set flag1");

    // R11 write wins over increment
    wr(0, 8'h01); wr(1, 8'h01);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h55;
    repeat (30) cyc();
    wr_en = 1'b0;
    rd(2, 8'h55, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule